// File: doc/BRIEF.md
# Buffered-Compare PWM Timer with Hardware Swap Request

This block is a left-aligned PWM timer. It runs on a fast system clock, and its counter advances only on a slower count-enable tick. A period register sets the cycle length. The active compare value sets how long the output stays high at the start of each cycle. A second compare value waits in a buffer. An external swap request, taken from a rising edge on a hardware input, exchanges the active and buffered compare values at the next terminal count. Successive cycles can therefore carry two different pulse widths, for example to encode a stream of bits.

The swap input is sampled on the fast clock through a short synchronizer. A request lasting a single fast-clock cycle is captured and kept until the cycle boundary, even after the input has dropped again. When the enable input is deasserted, the counter returns to zero and any pending request is dropped. The period and buffer registers accept writes at any time. The active compare value can be written directly only while the timer is disabled.

Top module: `pwm_swap_timer`

## Requirements
- R1: After reset, `pwm_out`, `tc_pulse` and `cmp_match` are 0 and the counter is 0.
- R2: With a period value P (P>0) and the timer enabled, the counter steps 0,1,…,P on successive ticks and then wraps to 0. Each cycle therefore spans P+1 ticks. `tc_pulse` is high for one clock after the tick that wraps, and after no other tick.
- R3: With an active compare value C where 0<C≤P, `pwm_out` is high while the counter is below C, which gives exactly C high ticks per cycle.
- R4: A rising edge on `switch_in`, even one lasting a single clock, sets a pending swap request that holds until the next wrap. A level held high across several wraps raises only one request.
- R5: At a wrap with a request pending, the active and buffered compare values are exchanged and the request is cleared. The cycle in which the request arrived keeps its old width, and the next cycle uses the new one.
- R6: With no request pending, a wrap leaves both compare values unchanged.
- R7: With a period value of 0, `pwm_out` stays low while the counter keeps running, and every tick produces a `tc_pulse`.
- R8: If C ≥ P+1, `pwm_out` stays high for all P+1 ticks of the cycle.
- R9: A write to the active compare value is ignored while enabled and takes effect while disabled. A buffer write takes effect at once and becomes the width applied after the next swap.
- R10: While `enable` is low, `pwm_out` is low, the counter is held at 0 and any pending swap request is cleared.
- R11: `cmp_match` is high for one clock after the tick on which the counter's new value equals the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds the counter at 0 and clears the request |
| cnt_tick | input | 1 | Count-enable tick, one clock wide |
| switch_in | input | 1 | Hardware swap request, edge detected |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | 16 | Period value (cycle length minus one) |
| cmp_we | input | 1 | Active compare write strobe (used only when disabled) |
| cmp_wdata | input | 16 | Active compare value |
| buf_we | input | 1 | Compare buffer write strobe |
| buf_wdata | input | 16 | Compare buffer value |
| pwm_out | output | 1 | PWM output |
| tc_pulse | output | 1 | Terminal-count pulse |
| cmp_match | output | 1 | Compare-match pulse |

## Verification
The hardest case to reach is a swap request that arrives as a one-clock pulse and has already ended long before the cycle boundary. The bench drives exactly that pulse while the counter sits at zero. It then measures the width of the current cycle and of the following one, tick by tick. A switch level held high across two boundaries checks that only the edge counts. Dropping `enable` with a request pending checks that the request is discarded.

// File: rtl/pwm_swap_pkg.sv
package pwm_swap_pkg;
    parameter int unsigned CW = 16;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic tc;
        logic match;
    } core_state_t;

    typedef struct packed {
        cnt_t period;
        cnt_t act;
        cnt_t bufv;
        logic pend;
    } ctl_state_t;
endpackage

// File: rtl/swt_edge_sync.sv
module swt_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int unsigned DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // Newest synchronized sample high, previous one low.
    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter
    import pwm_swap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  cnt_t period,
    input  cnt_t cmp,
    output logic wrap,
    output cnt_t count,
    output logic tc,
    output logic match
);
    core_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.tc    = 1'b0;
        s_d.match = 1'b0;
        wrap      = run && tick && (s_q.cnt >= period);
        if (!run) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt   = wrap ? '0 : cnt_t'(s_q.cnt + 1'b1);
            s_d.tc    = wrap;
            s_d.match = (s_d.cnt == cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign tc    = s_q.tc;
    assign match = s_q.match;
endmodule

// File: rtl/pwm_swap_timer.sv
module pwm_swap_timer
    import pwm_swap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cnt_tick,
    input  logic          switch_in,
    input  logic          period_we,
    input  logic [CW-1:0] period_wdata,
    input  logic          cmp_we,
    input  logic [CW-1:0] cmp_wdata,
    input  logic          buf_we,
    input  logic [CW-1:0] buf_wdata,
    output logic          pwm_out,
    output logic          tc_pulse,
    output logic          cmp_match
);
    ctl_state_t c_d, c_q;
    logic       sw_rise;
    logic       wrap;
    cnt_t       count;

    // Plain views of the state for the bound checker.
    cnt_t period_q, act_q, buf_q;
    logic pend_q;
    assign period_q = c_q.period;
    assign act_q    = c_q.act;
    assign buf_q    = c_q.bufv;
    assign pend_q   = c_q.pend;

    swt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (switch_in),
        .rise (sw_rise)
    );

    pwm_tick_counter u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .tick  (cnt_tick),
        .period(c_q.period),
        .cmp   (c_q.act),
        .wrap  (wrap),
        .count (count),
        .tc    (tc_pulse),
        .match (cmp_match)
    );

    always_comb begin
        c_d = c_q;
        if (period_we) c_d.period = period_wdata;
        if (!enable) begin
            c_d.pend = 1'b0;
            if (cmp_we) c_d.act = cmp_wdata;
        end else begin
            if (wrap && c_q.pend) begin
                c_d.act  = c_q.bufv;
                c_d.bufv = c_q.act;
                c_d.pend = 1'b0;
            end
            if (sw_rise) c_d.pend = 1'b1;
        end
        if (buf_we) c_d.bufv = buf_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pwm_out = enable && (c_q.period != '0) && (count < c_q.act);
endmodule

// File: rtl/pwm_swap_checks.sv
module pwm_swap_checks
    import pwm_swap_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cnt_tick,
    input logic buf_we,
    input logic pwm_out,
    input logic wrap,
    input cnt_t count,
    input cnt_t period_q,
    input cnt_t act_q,
    input cnt_t buf_q,
    input logic pend_q
);
    assert_zero_period_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0) |-> !pwm_out);

    assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pwm_out);

    assert_disabled_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pend_q && count == '0));

    assert_full_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && period_q != '0 && act_q > period_q) |-> pwm_out);

    assert_swap_exchange_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap && pend_q && !buf_we) |=>
            (act_q == $past(buf_q) && buf_q == $past(act_q)));

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(wrap && pend_q)) |=> $stable(act_q));

    assert_no_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap && !pend_q && !buf_we) |=> ($stable(act_q) && $stable(buf_q)));
endmodule

bind pwm_swap_timer pwm_swap_checks u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cnt_tick(cnt_tick),
    .buf_we  (buf_we),
    .pwm_out (pwm_out),
    .wrap    (wrap),
    .count   (count),
    .period_q(period_q),
    .act_q   (act_q),
    .buf_q   (buf_q),
    .pend_q  (pend_q)
);

// File: tb/tb_pwm_swap_timer.sv
`timescale 1ns/1ps
module tb_pwm_swap_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0, cnt_tick = 1'b0, switch_in = 1'b0;
    logic         period_we = 1'b0, cmp_we = 1'b0, buf_we = 1'b0;
    logic [W-1:0] period_wdata = '0, cmp_wdata = '0, buf_wdata = '0;
    logic         pwm_out, tc_pulse, cmp_match;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_swap_timer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_tick(cnt_tick),
        .switch_in(switch_in), .period_we(period_we), .period_wdata(period_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .pwm_out(pwm_out), .tc_pulse(tc_pulse), .cmp_match(cmp_match)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int which, input int val);
        case (which)
            0: begin period_we = 1'b1; period_wdata = W'(val); end
            1: begin cmp_we = 1'b1; cmp_wdata = W'(val); end
            default: begin buf_we = 1'b1; buf_wdata = W'(val); end
        endcase
        @(negedge clk);
        period_we = 1'b0; cmp_we = 1'b0; buf_we = 1'b0;
    endtask

    task automatic do_tick(output logic tc, output logic m);
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
        tc = tc_pulse;
        m  = cmp_match;
        @(negedge clk);
    endtask

    // Runs n ticks from counter 0; reports high ticks, tc placement, first match index.
    task automatic run_cycle(input int n, output int highs, output bit tc_ok,
                             output int match_idx, output int match_cnt);
        logic tc, m;
        highs = 0; tc_ok = 1'b1; match_idx = -1; match_cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            do_tick(tc, m);
            if (tc !== (i == n - 1)) tc_ok = 1'b0;
            if (m) begin
                match_cnt++;
                if (match_idx < 0) match_idx = i;
            end
        end
    endtask

    task automatic pulse_switch();
        switch_in = 1'b1;
        @(negedge clk);
        switch_in = 1'b0;
        idle(4);
    endtask

    task automatic expect_width(input int exp, input string tag);
        int h, mi, mc; bit ok;
        run_cycle(5, h, ok, mi, mc);
        chk(h == exp, tag, h, exp);
        chk(ok, {tag, " tc"}, ok, 1);
    endtask

    task automatic t_reset();
        chk(pwm_out == 1'b0 && tc_pulse == 1'b0 && cmp_match == 1'b0, "R1 reset outputs",
            {pwm_out, tc_pulse, cmp_match}, 0);
    endtask

    task automatic t_basic();
        int h, mi, mc; bit ok;
        wr(0, 4); wr(1, 1); wr(2, 3);
        enable = 1'b1; idle(1);
        run_cycle(5, h, ok, mi, mc);
        chk(ok, "R2 tc only on 5th tick", ok, 1);
        chk(h == 1, "R3 width cmp=1", h, 1);
        chk(mi == 0 && mc == 1, "R11 match on tick 0", mi, 0);
    endtask

    task automatic t_swap_pulse();
        pulse_switch();
        expect_width(1, "R5 current cycle keeps width");
        expect_width(3, "R4 one-clock pulse swapped");
        expect_width(3, "R6 no second swap");
    endtask

    task automatic t_level();
        int h, mi, mc; bit ok;
        switch_in = 1'b1; idle(4);
        expect_width(3, "R4 level first cycle");
        expect_width(1, "R4 level swapped once");
        run_cycle(5, h, ok, mi, mc);
        chk(h == 1, "R4 level no retrigger", h, 1);
        chk(mi == 0, "R11 match after swap", mi, 0);
        switch_in = 1'b0; idle(3);
    endtask

    task automatic t_writes();
        wr(1, 4);
        expect_width(1, "R9 active write ignored when enabled");
        wr(2, 2);
        pulse_switch();
        expect_width(1, "R9 pre-swap");
        expect_width(2, "R9 buffer write used after swap");
    endtask

    task automatic t_full();
        int h, mi, mc; bit ok;
        enable = 1'b0; idle(1);
        chk(pwm_out == 1'b0, "R10 disabled low", pwm_out, 0);
        wr(1, 5); enable = 1'b1; idle(1);
        expect_width(5, "R8 cmp=P+1 full high");
        enable = 1'b0; wr(1, 9); enable = 1'b1; idle(1);
        run_cycle(5, h, ok, mi, mc);
        chk(h == 5, "R8 cmp=9 full high", h, 5);
        chk(mc == 0, "R11 no match above period", mc, 0);
    endtask

    task automatic t_zero();
        logic tc, m;
        int lows = 0, tcs = 0;
        wr(0, 0);
        for (int i = 0; i < 3; i++) begin
            if (!pwm_out) lows++;
            do_tick(tc, m);
            if (tc) tcs++;
        end
        chk(lows == 3, "R7 output low with period 0", lows, 3);
        chk(tcs == 3, "R7 counter still wraps", tcs, 3);
        wr(0, 4);
        expect_width(5, "R7 resumes after period restored");
    endtask

    task automatic t_disable();
        logic tc, m;
        pulse_switch();
        do_tick(tc, m); do_tick(tc, m);
        enable = 1'b0; idle(2);
        chk(pwm_out == 1'b0, "R10 low while disabled", pwm_out, 0);
        enable = 1'b1; idle(1);
        expect_width(5, "R10 counter restarted at 0");
        expect_width(5, "R10 pending request dropped");
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1; idle(2);
        t_reset();
        t_basic();
        t_swap_pulse();
        t_level();
        t_writes();
        t_full();
        t_zero();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule